// File: doc/BRIEF.md
# Flash Transfer Chunk Sequencer

This block accepts one flash transfer request, given as a start address, a byte count, a direction and a data-phase flag, and breaks it into a series of smaller operations that a serial flash command controller can run one at a time. For each operation it presents an address and an encoded length. It then waits for the controller to report completion before it presents the next one.

A chunk never crosses a 256-byte page edge. Its length is always one of the values the controller's count field can hold: any value from 1 to 8, or a multiple of 8 up to 64. A request with no data phase produces one operation of zero length. If the controller reports an error when an operation completes, the whole request is abandoned and an error pulse is raised. When the remaining count reaches zero, a done pulse is raised.

Top module: `flash_chunker`

## Requirements
- R1: After reset, `busy`, `chunk_valid`, `done` and `error` are all low.
- R2: A request (`req_valid` high) is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high until the cycle in which `done` or `error` pulses. While `busy` is high, requests are ignored.
- R3: No chunk crosses a 256-byte boundary. The address bits above bit 7 are the same for the first and last byte of every chunk.
- R4: The chunk length is derived from a candidate, which is the smaller of the remaining count and the distance to the next 256-byte boundary. A candidate of 64 or more gives a length of 64. A candidate from 8 to 63 is rounded down to a multiple of 8. A candidate below 8 is used as it is.
- R5: `chunk_len_m1` carries the chunk length minus one in 6 bits, so the value 63 means 64 bytes. When there is no data phase, `chunk_len_m1` is 0 and `chunk_has_data` is low.
- R6: After a chunk completes (`chunk_ack` high while `chunk_valid` is high), the next chunk's address equals the previous address plus the previous length. The lengths of all chunks sum to the requested count.
- R7: When there is no data phase (`req_data` low), exactly one operation is issued, whatever the byte count.
- R8: If `chunk_err` is high at completion, `error` pulses for one cycle, `busy` falls, and no further chunk is issued.
- R9: `done` pulses for one cycle after the completion that brings the remaining count to zero. A request with a data phase and a zero count issues one zero-length operation.
- R10: `chunk_write` and `chunk_has_data` hold the direction and data-phase flags of the accepted request for every chunk of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Start address |
| req_count | input | CW | Byte count |
| req_write | input | 1 | 1 = shift data out |
| req_data | input | 1 | Request has a data phase |
| busy | output | 1 | Request in progress |
| chunk_valid | output | 1 | Chunk presented |
| chunk_addr | output | AW | Chunk address |
| chunk_len_m1 | output | 6 | Chunk length minus one |
| chunk_write | output | 1 | Direction of chunk |
| chunk_has_data | output | 1 | Chunk has a data phase |
| chunk_ack | input | 1 | Chunk completion |
| chunk_err | input | 1 | Completion carries an error |
| done | output | 1 | Request finished pulse |
| error | output | 1 | Request aborted pulse |

## Verification
If the remaining count or address register goes wrong, it shows up at the first chunk presented afterwards. A wrong value appears on `chunk_addr` or `chunk_len_m1` in the same cycle `chunk_valid` is high. A drift in the remaining count appears later, as an extra chunk or a missing chunk, or as `done` arriving at the wrong completion. A state machine stuck in one state shows as `busy` staying high with no chunk, or as a chunk that is still presented after an error.

// File: rtl/flash_chunker.sv
module flash_chunker #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic          req_write,
  input  logic          req_data,
  output logic          busy,
  output logic          chunk_valid,
  output logic [AW-1:0] chunk_addr,
  output logic [5:0]    chunk_len_m1,
  output logic          chunk_write,
  output logic          chunk_has_data,
  input  logic          chunk_ack,
  input  logic          chunk_err,
  output logic          done,
  output logic          error
);
  localparam int PW = 8;
  localparam int LW = 7;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          wr_q, dp_q;

  logic [PW:0]   to_edge;
  logic [CW-1:0] cand;
  logic [LW-1:0] len;
  logic          last;

  assign to_edge = (PW+1)'(1 << PW) - {1'b0, addr_q[PW-1:0]};
  assign cand    = (rem_q < CW'(to_edge)) ? rem_q : CW'(to_edge);

  always_comb begin
    if (!dp_q)               len = '0;
    else if (cand >= CW'(64)) len = LW'(64);
    else if (cand >= CW'(8))  len = {cand[LW-1:3], 3'b000};
    else                      len = cand[LW-1:0];
  end

  assign last           = !dp_q || (rem_q == CW'(len));
  assign chunk_addr     = addr_q;
  assign chunk_len_m1   = (len == '0) ? 6'd0 : 6'(len - LW'(1));
  assign chunk_write    = wr_q;
  assign chunk_has_data = dp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      chunk_valid <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
      addr_q      <= '0;
      rem_q       <= '0;
      wr_q        <= 1'b0;
      dp_q        <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy        <= 1'b1;
          chunk_valid <= 1'b1;
          addr_q      <= req_addr;
          rem_q       <= req_data ? req_count : '0;
          wr_q        <= req_write;
          dp_q        <= req_data;
        end
      end else if (chunk_valid && chunk_ack) begin
        if (chunk_err) begin
          busy        <= 1'b0;
          chunk_valid <= 1'b0;
          error       <= 1'b1;
        end else if (last) begin
          busy        <= 1'b0;
          chunk_valid <= 1'b0;
          done        <= 1'b1;
          rem_q       <= '0;
        end else begin
          addr_q <= addr_q + AW'(len);
          rem_q  <= rem_q - CW'(len);
        end
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(!rst_n) |-> !busy && !chunk_valid && !done && !error);

  a_r3_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && chunk_has_data |->
      ((chunk_addr + AW'(chunk_len_m1)) >> PW) == (chunk_addr >> PW));

  a_r5_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && chunk_len_m1 >= 6'd8 |-> chunk_len_m1[2:0] == 3'b111);

  a_r6_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && chunk_ack && !chunk_err && !last |=>
      chunk_valid && chunk_addr == $past(chunk_addr) + AW'($past(chunk_len_m1)) + AW'(1));

  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && chunk_ack && chunk_err |=> error && !chunk_valid && !busy);

  a_r2_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy);
endmodule

// File: tb/flash_chunker_test.sv
module flash_chunker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_data = 0, chunk_ack = 0, chunk_err = 0;
  logic [AW-1:0] req_addr = 0;
  logic [CW-1:0] req_count = 0;
  logic busy, chunk_valid, chunk_write, chunk_has_data, done, error;
  logic [AW-1:0] chunk_addr;
  logic [5:0] chunk_len_m1;

  int tests = 0, fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1; tests = tests + 1;
      $display("FAIL watchdog R2 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  flash_chunker #(.AW(AW), .CW(CW)) uut (.*);

  task automatic chk(input string r, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // addr, count, write, data
  localparam int NV = 7;
  localparam logic [AW+CW+1:0] VEC [NV] = '{
    {24'h000000, 16'd200, 1'b0, 1'b1},
    {24'h0000F0, 16'd40,  1'b1, 1'b1},
    {24'h0001FD, 16'd13,  1'b0, 1'b1},
    {24'h000005, 16'd5,   1'b1, 1'b1},
    {24'h000100, 16'd70,  1'b0, 1'b1},
    {24'h000010, 16'd99,  1'b1, 1'b0},
    {24'h000020, 16'd0,   1'b0, 1'b1}
  };

  function automatic int ref_len(input int a, input int rem, input bit dp);
    int c, e;
    if (!dp) return 0;
    e = 256 - (a % 256);
    c = rem < e ? rem : e;
    if (c >= 64) return 64;
    if (c >= 8) return c - c % 8;
    return c;
  endfunction

  task automatic run_req(input int a, input int n, input bit w, input bit dp,
                         input int err_at);
    int ea, rem, k, l;
    @(negedge clk);
    req_valid = 1; req_addr = AW'(a); req_count = CW'(n); req_write = w; req_data = dp;
    @(negedge clk);
    req_valid = 0;
    chk("R2 busy after accept", busy, 1);
    ea = a; rem = dp ? n : 0; k = 0;
    forever begin
      l = ref_len(ea, rem, dp);
      chk("R6 chunk valid", chunk_valid, 1);
      chk("R6 addr", chunk_addr, ea);
      chk("R4 R5 len_m1", chunk_len_m1, l == 0 ? 0 : l - 1);
      chk("R10 write", chunk_write, w);
      chk("R10 data", chunk_has_data, dp);
      chk("R3 page", (ea + (l == 0 ? 0 : l - 1)) / 256, ea / 256);
      chunk_ack = 1; chunk_err = (k == err_at);
      @(negedge clk);
      chunk_ack = 0; chunk_err = 0;
      if (k == err_at) begin
        chk("R8 error pulse", error, 1);
        chk("R8 no chunk", chunk_valid, 0);
        chk("R8 busy low", busy, 0);
        @(negedge clk);
        chk("R8 error one cycle", error, 0);
        return;
      end
      ea += l; rem -= l; k++;
      if (rem == 0 || !dp) begin
        chk("R9 done", done, 1);
        chk("R7 R9 idle", busy, 0);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        return;
      end
      chk("R9 not done yet", done, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 valid", chunk_valid, 0);
    chk("R1 done/err", done | error, 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      run_req(int'(VEC[i][AW+CW+1:CW+2]), int'(VEC[i][CW+1:2]), VEC[i][1], VEC[i][0], -1);
    // error on third chunk
    run_req(0, 200, 1, 1, 2);
    // request while busy ignored
    @(negedge clk);
    req_valid = 1; req_addr = 24'h40; req_count = 16'd16; req_data = 1; req_write = 0;
    @(negedge clk);
    req_addr = 24'h999; req_count = 16'd3;
    @(negedge clk);
    req_valid = 0;
    chk("R2 held addr", chunk_addr, 24'h40);
    chk("R2 held len", chunk_len_m1, 15);
    chunk_ack = 1; @(negedge clk); chunk_ack = 0;
    chk("R9 done single", done, 1);
    @(negedge clk);
    chk("R2 no second req", chunk_valid, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule